// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a synchronous request/acknowledge bus and an external asynchronous static RAM with a 17-bit address, an 8-bit bidirectional data bus, a complementary pair of chip selects (one active low, one active high), an active-low output enable and an active-low write enable. A requester presents one byte read or write at a time. The controller turns it into a RAM cycle whose every phase lasts a whole number of system clocks, and it pulses an acknowledge when the cycle is complete.

All RAM timing minimums are parameters in nanoseconds, together with the clock period. Each minimum is rounded up to whole cycles, and the larger constraint wins wherever several of them bound the same phase. With the defaults (10 ns clock, 55 ns grade), a read holds output enable low for 6 cycles. A write holds write enable low for 5 cycles. The controller waits at least 2 cycles after output enable rises before it drives the data bus. When no access is running, the RAM is deselected so that it sits in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high, and on the first clock after it, `ram_sel_n`=1, `ram_sel_p`=0, `ram_oe_n`=1, `ram_we_n`=1 and `req_ack`=0. The controller does not drive `ram_dq`.
- R2: Outside an access, the RAM is deselected (`ram_sel_n`=1, `ram_sel_p`=0). The two selects always carry opposite levels.
- R3: A read (`req_write`=0) selects the RAM with `ram_we_n`=1 and `ram_oe_n`=0 and returns the byte last written to that address on `rd_data`. `ram_oe_n` and `ram_we_n` are never low together.
- R4: During a read, `ram_oe_n` stays low for at least the rounded-up read window, which is the largest of the cycle time, the address access time and the output-enable access time (6 cycles by default). The read byte is registered at the end of that window.
- R5: A write holds `ram_we_n` low for at least the rounded-up largest of the pulse width, the address-to-write-end time, the data setup time and the cycle time less two cycles (5 cycles by default). The write ends by `ram_we_n` rising while both selects are still active.
- R6: Write data is driven on `ram_dq` in every cycle that `ram_we_n` is low, and it is still driven in the cycle in which `ram_we_n` has just risen.
- R7: The controller starts driving `ram_dq` only after `ram_oe_n` has been high for at least the rounded-up output-disable time (2 cycles by default). It never drives the bus while `ram_oe_n` is low.
- R8: `req_ack` is high for exactly one cycle per request. On a read, `rd_data` holds the read byte from that cycle onward. A request is accepted only while idle and outside an acknowledge cycle.
- R9: `ram_addr` does not change while the RAM stays selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Registered read byte |
| ram_addr | output | 17 | RAM address pins |
| ram_dq | inout | 8 | RAM bidirectional data pins |
| ram_sel_n | output | 1 | Active-low chip select |
| ram_sel_p | output | 1 | Active-high chip select |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write enable |

## Verification
The checks assume that the requester keeps `req_valid`, `req_write`, `req_addr` and `req_wdata` steady from the cycle a request is raised until its acknowledge, and that it lowers or replaces the request in the acknowledge cycle. The checks also assume that the RAM drives `ram_dq` only while it is selected with `ram_oe_n` low and `ram_we_n` high. The bench drives the request lines only on falling clock edges, and only between acknowledges. Its RAM model drives data under exactly that select-and-enable condition. The one deliberate break in the protocol is a reset in the middle of a write pulse, and the assertions are disabled across it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD
    } ctl_state_e;

    // Internal pin intent, all active high
    typedef struct packed {
        logic sel;
        logic oe;
        logic we;
        logic drive;
    } pin_ctl_t;

    // Convert a minimum time in ns to whole clock cycles, rounding up
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_bus_turn.sv
module sram_bus_turn #(
    parameter int TA_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic oe_active,
    output logic bus_free
);
    localparam int TW = $clog2(TA_CYC + 1) + 1;

    logic [TW-1:0] quiet_q;

    // Counts cycles since the RAM output enable was last active, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= TW'(TA_CYC);
        end else if (oe_active) begin
            quiet_q <= '0;
        end else if (quiet_q < TW'(TA_CYC)) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    assign bus_free = (quiet_q >= TW'(TA_CYC));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC = 6,
    parameter int WR_CYC = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  logic     req_write,
    input  logic     bus_free,
    output pin_ctl_t pins,
    output logic     load,
    output logic     capture,
    output logic     ack
);
    localparam int CNT_MAX = max_i(RD_CYC, WR_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    ctl_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    pin_ctl_t         pins_q;
    logic             ack_q;

    assign load    = (st_q == ST_IDLE) && req_valid && !ack_q;
    assign capture = (st_q == ST_RD) && (cnt_q == CNT_W'(RD_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            pins_q <= '0;
            ack_q  <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (load) begin
                        pins_q.sel <= 1'b1;
                        cnt_q      <= '0;
                        if (req_write) begin
                            st_q <= ST_WR_SETUP;
                        end else begin
                            pins_q.oe <= 1'b1;
                            st_q      <= ST_RD;
                        end
                    end
                end
                ST_RD: begin
                    if (capture) begin
                        pins_q.sel <= 1'b0;
                        pins_q.oe  <= 1'b0;
                        ack_q      <= 1'b1;
                        st_q       <= ST_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WR_SETUP: begin
                    if (bus_free) begin
                        pins_q.we    <= 1'b1;
                        pins_q.drive <= 1'b1;
                        cnt_q        <= '0;
                        st_q         <= ST_WR_PULSE;
                    end
                end
                ST_WR_PULSE: begin
                    if (cnt_q == CNT_W'(WR_CYC - 1)) begin
                        pins_q.we <= 1'b0;
                        st_q      <= ST_WR_HOLD;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WR_HOLD: begin
                    pins_q.drive <= 1'b0;
                    pins_q.sel   <= 1'b0;
                    ack_q        <= 1'b1;
                    st_q         <= ST_IDLE;
                end
                default: begin
                    st_q   <= ST_IDLE;
                    pins_q <= '0;
                end
            endcase
        end
    end

    assign pins = pins_q;
    assign ack  = ack_q;

endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              drive,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] rdata_out,
    inout  wire  [DATA_W-1:0] dq
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (load) begin
                addr_q  <= addr_in;
                wdata_q <= wdata_in;
            end
            if (capture) begin
                rdata_q <= dq;
            end
        end
    end

    assign dq        = drive ? wdata_q : {DATA_W{1'bz}};
    assign addr_out  = addr_q;
    assign rdata_out = rdata_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int T_RC_NS  = 55,
    parameter int T_AA_NS  = 55,
    parameter int T_DOE_NS = 25,
    parameter int T_WC_NS  = 55,
    parameter int T_AW_NS  = 50,
    parameter int T_PWE_NS = 40,
    parameter int T_SD_NS  = 25,
    parameter int T_HZ_NS  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ram_addr,
    inout  wire  [DATA_W-1:0] ram_dq,
    output logic              ram_sel_n,
    output logic              ram_sel_p,
    output logic              ram_oe_n,
    output logic              ram_we_n
);
    localparam int RD_CYC = max_i(ns_to_cyc(T_RC_NS, CLK_NS),
                                  max_i(ns_to_cyc(T_AA_NS, CLK_NS),
                                        ns_to_cyc(T_DOE_NS, CLK_NS)));
    localparam int WC_PULSE = max_i(1, ns_to_cyc(T_WC_NS, CLK_NS) - 2);
    localparam int WR_CYC = max_i(max_i(ns_to_cyc(T_PWE_NS, CLK_NS),
                                        ns_to_cyc(T_AW_NS, CLK_NS)),
                                  max_i(ns_to_cyc(T_SD_NS, CLK_NS), WC_PULSE));
    localparam int TA_CYC = max_i(1, ns_to_cyc(T_HZ_NS, CLK_NS));

    pin_ctl_t pins;
    logic     bus_free;
    logic     load;
    logic     capture;
    logic     dq_oe;

    sram_bus_turn #(.TA_CYC(TA_CYC)) turn_i (
        .clk       (clk),
        .rst       (rst),
        .oe_active (pins.oe),
        .bus_free  (bus_free)
    );

    sram_seq_fsm #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .bus_free  (bus_free),
        .pins      (pins),
        .load      (load),
        .capture   (capture),
        .ack       (req_ack)
    );

    assign dq_oe = pins.drive;

    sram_dq_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) port_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .drive     (dq_oe),
        .capture   (capture),
        .addr_in   (req_addr),
        .wdata_in  (req_wdata),
        .addr_out  (ram_addr),
        .rdata_out (rd_data),
        .dq        (ram_dq)
    );

    assign ram_sel_n = ~pins.sel;
    assign ram_sel_p = pins.sel;
    assign ram_oe_n  = ~pins.oe;
    assign ram_we_n  = ~pins.we;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int TA_CYC = 2,
    parameter int WR_CYC = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ack,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_sel_n,
    input logic              ram_sel_p,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic              drive_en
);
    logic [7:0] we_lo_cnt;
    logic [7:0] oe_hi_cnt;
    logic       selected;

    assign selected = !ram_sel_n && ram_sel_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_lo_cnt <= '0;
            oe_hi_cnt <= 8'hFF;
        end else begin
            we_lo_cnt <= ram_we_n ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
            oe_hi_cnt <= !ram_oe_n ? 8'd0 : ((oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1);
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (ram_sel_n && !ram_sel_p && ram_oe_n && ram_we_n && !req_ack && !drive_en)); // R1
    AST_SEL_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        ram_sel_n != ram_sel_p); // R2
    AST_NO_OE_WE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(!ram_oe_n && !ram_we_n)); // R3
    AST_WE_UNDER_SELECT: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> selected); // R5
    AST_WE_ENDS_SELECTED: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we_n) |-> selected); // R5
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we_n) |-> (we_lo_cnt >= 8'(WR_CYC))); // R5
    AST_DRIVE_WITH_WE: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> drive_en); // R6
    AST_DRIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we_n) |-> drive_en); // R6
    AST_NO_DRIVE_OE_LOW: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> ram_oe_n); // R7
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_en) |-> (oe_hi_cnt >= 8'(TA_CYC))); // R7
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack); // R8
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (selected && $past(selected)) |-> $stable(ram_addr)); // R9

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .TA_CYC (TA_CYC),
    .WR_CYC (WR_CYC)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_ack   (req_ack),
    .ram_addr  (ram_addr),
    .ram_sel_n (ram_sel_n),
    .ram_sel_p (ram_sel_p),
    .ram_oe_n  (ram_oe_n),
    .ram_we_n  (ram_we_n),
    .drive_en  (dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int EXP_RD_OE  = 6;   // ceil(55/10)
    localparam int EXP_WE_LO  = 5;   // ceil(50/10)
    localparam int EXP_TA     = 2;   // ceil(20/10)
    localparam int NVEC       = 10;

    typedef struct packed {
        logic        wr;
        logic [16:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 17'h00000, 8'hA5},
        '{1'b1, 17'h1FFFF, 8'h3C},
        '{1'b0, 17'h00000, 8'hA5},
        '{1'b0, 17'h1FFFF, 8'h3C},
        '{1'b1, 17'h0AAAA, 8'h55},
        '{1'b1, 17'h15555, 8'hAA},
        '{1'b0, 17'h0AAAA, 8'h55},
        '{1'b0, 17'h15555, 8'hAA},
        '{1'b1, 17'h00000, 8'h0F},
        '{1'b0, 17'h00000, 8'h0F}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ack;
    logic [7:0]  rd_data;
    logic [16:0] ram_addr;
    wire  [7:0]  ram_dq;
    logic        ram_sel_n;
    logic        ram_sel_p;
    logic        ram_oe_n;
    logic        ram_we_n;

    int nchk = 0, nfail = 0;
    int mchk = 0, mfail = 0;
    int wd_cnt = 0;
    logic [7:0] cur_wdata = '0;
    logic       done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sram_async_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ack   (req_ack),
        .rd_data   (rd_data),
        .ram_addr  (ram_addr),
        .ram_dq    (ram_dq),
        .ram_sel_n (ram_sel_n),
        .ram_sel_p (ram_sel_p),
        .ram_oe_n  (ram_oe_n),
        .ram_we_n  (ram_we_n)
    );

    // RAM model: drives only when selected, output enabled and not writing
    logic [7:0] mdl [logic [16:0]];
    logic [7:0] mdl_q = 8'hEE;
    wire        mdl_sel = !ram_sel_n && ram_sel_p;

    always @(posedge clk) mdl_q <= mdl.exists(ram_addr) ? mdl[ram_addr] : 8'hEE;
    always @(posedge ram_we_n) if (mdl_sel) mdl[ram_addr] = ram_dq;
    assign ram_dq = (mdl_sel && !ram_oe_n && ram_we_n) ? mdl_q : 8'hzz;

    // Pin timing monitor
    logic        p_we = 1'b1, p_oe = 1'b1, p_ack = 1'b0, p_sel = 1'b0;
    logic [16:0] p_addr = '0;
    int          oe_hi = 99, oe_lo = 0, we_lo = 0;

    always @(negedge clk) begin
        if (!rst) begin
            mchk++;
            if (!ram_oe_n && !ram_we_n) begin
                mfail++; $display("FAIL R3: oe_n=%0b we_n=%0b expected not both low", ram_oe_n, ram_we_n);
            end
            if (ram_sel_n == ram_sel_p) begin
                mfail++; $display("FAIL R2: sel_n=%0b sel_p=%0b expected opposite", ram_sel_n, ram_sel_p);
            end
            if (p_we && !ram_we_n && oe_hi < EXP_TA) begin
                mfail++; $display("FAIL R7: oe high %0d cycles expected >= %0d", oe_hi, EXP_TA);
            end
            if (!ram_we_n && ram_dq !== cur_wdata) begin
                mfail++; $display("FAIL R6: dq=%h expected %h during we low", ram_dq, cur_wdata);
            end
            if (!p_we && ram_we_n) begin
                if (we_lo < EXP_WE_LO) begin
                    mfail++; $display("FAIL R5: we low %0d cycles expected >= %0d", we_lo, EXP_WE_LO);
                end
                if (!mdl_sel) begin
                    mfail++; $display("FAIL R5: selected=%0b at write end expected 1", mdl_sel);
                end
                if (ram_dq !== cur_wdata) begin
                    mfail++; $display("FAIL R6: hold dq=%h expected %h", ram_dq, cur_wdata);
                end
            end
            if (!p_oe && ram_oe_n && oe_lo < EXP_RD_OE) begin
                mfail++; $display("FAIL R4: oe low %0d cycles expected >= %0d", oe_lo, EXP_RD_OE);
            end
            if (p_ack && req_ack) begin
                mfail++; $display("FAIL R8: ack high %0d cycles expected 1", 2);
            end
            if (p_sel && mdl_sel && ram_addr != p_addr) begin
                mfail++; $display("FAIL R9: addr=%h expected %h while selected", ram_addr, p_addr);
            end
            oe_hi = ram_oe_n ? (oe_hi < 99 ? oe_hi + 1 : oe_hi) : 0;
            oe_lo = ram_oe_n ? 0 : oe_lo + 1;
            we_lo = ram_we_n ? 0 : we_lo + 1;
        end
        p_we   = ram_we_n;
        p_oe   = ram_oe_n;
        p_ack  = req_ack;
        p_sel  = mdl_sel;
        p_addr = ram_addr;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nchk + mchk, nfail + mfail);
        $finish;
    endtask

    task automatic pins_quiet(input string tag);
        chk(ram_sel_n && !ram_sel_p && ram_oe_n && ram_we_n && !req_ack, tag,
            {ram_sel_n, ram_sel_p, ram_oe_n, ram_we_n, req_ack}, 5'b10110);
    endtask

    task automatic run_req(input logic wr, input logic [16:0] a, input logic [7:0] d);
        int n = 0;
        cur_wdata = d;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_valid = 1'b1;
        @(negedge clk);
        while (!req_ack && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(req_ack == 1'b1, "R8 ack", req_ack, 1);
        if (!wr) chk(rd_data == d, "R3 read data", rd_data, d);
        chk(ram_sel_n && !ram_sel_p, "R2 deselect after access", {ram_sel_n, ram_sel_p}, 2'b10);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!req_ack, "R8 single ack", req_ack, 0);
    endtask

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 50000 && !done) begin
            done = 1'b1;
            mfail++;
            $display("FAIL watchdog: cycles %0d expected < %0d", wd_cnt, 50000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        pins_quiet("R1 reset pins");
        rst = 1'b0;
        @(negedge clk);
        pins_quiet("R1 first cycle after reset");

        for (int i = 0; i < NVEC; i++) begin
            run_req(VECS[i].wr, VECS[i].addr, VECS[i].data);
        end

        // R2: long idle keeps the RAM in standby
        begin
            int sel_seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (mdl_sel) sel_seen++;
            end
            chk(sel_seen == 0, "R2 idle standby", sel_seen, 0);
        end

        // R1: reset in the middle of a write pulse
        cur_wdata = 8'h99;
        req_write = 1'b1;
        req_addr  = 17'h12345;
        req_wdata = 8'h99;
        req_valid = 1'b1;
        begin
            int n = 0;
            while (ram_we_n && n < 50) begin
                @(negedge clk);
                n++;
            end
        end
        chk(!ram_we_n, "R5 write pulse started", ram_we_n, 0);
        rst = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        pins_quiet("R1 reset mid write");
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        pins_quiet("R1 recovery");

        // Data written before the reset survives and reads back
        run_req(1'b0, 17'h0AAAA, 8'h55);
        run_req(1'b0, 17'h1FFFF, 8'h3C);

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule